// File: doc/BRIEF.md
# Up/Down Timer Counter Core

This block is the counting stage of an 8-bit timer. A register holds the count. Each timer tick can move the count up by one, move it down by one, or clear it to zero. Ticks come from a vector of prescaler tap pulses that the block receives from outside. A 3-bit clock-select field picks which tap is used, and the value zero stops the counter. A 2-bit waveform-mode field picks the counting sequence, which is one of the following:

- plain up count that wraps,
- dual-slope up/down between the two ends,
- clear on a compare match,
- fast up count.

Mode encoding: `00` normal, `01` dual-slope, `10` clear-on-match, `11` fast.

The block drives combinational top and bottom indications and a direction bit. It also keeps a sticky overflow flag, and when that flag is set depends on the mode. Software can write the count through a bus write port at any time, whether or not the counter is running. The count is always readable on `cnt_o`. A bus write takes priority over any count step or clear in the same cycle.

Top module: `updown_tmr_core`

## Requirements
- R1: After reset the count is 0x00, the overflow flag is 0 and the direction bit is 0 (up).
- R2: With clock-select 0, no tap produces a tick and the count holds. With clock-select k (1..7), only `tap_i[k-1]` advances the counter, and every other tap has no effect.
- R3: In mode `00`, each tick adds one to the count, and the count wraps from 0xFF to 0x00.
- R4: In mode `01`, the count rises to 0xFF, then falls to 0x00, then rises again. The direction bit is 1 while the count is falling and 0 while it is rising.
- R5: In mode `10`, a tick while the count equals the compare value sets the count to 0x00. Any other tick adds one.
- R6: In mode `11`, the count advances exactly as in mode `00`.
- R7: `top_o` is 1 exactly when the count is 0xFF. `bottom_o` is 1 exactly when the count is 0x00.
- R8: A bus write loads the count on the next edge, whether or not the counter is stopped. It overrides any tick, compare clear or wrap in that cycle, and it raises no overflow.
- R9: The overflow flag is set as follows:
  - in modes `00`, `10` and `11`, by the tick that leaves 0xFF;
  - in mode `01`, by the falling tick that moves the count from 0x01 to 0x00;
  - in no other case. In particular, the turn at the top in mode `01` does not set it.
- R10: The overflow flag is cleared when `ovf_w1c` or `int_ack` is 1 at an edge. If a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 3 | Tick source select; 0 stops the counter |
| tap_i | input | 7 | Prescaler tap pulses; selected by `clk_sel` |
| wave_mode | input | 2 | Counting sequence select |
| cmp_val | input | 8 | Compare value for the clear-on-match mode |
| cpu_wr_en | input | 1 | Bus write strobe for the count |
| cpu_wr_data | input | 8 | Bus write data for the count |
| ovf_w1c | input | 1 | Software write-one to clear the overflow flag |
| int_ack | input | 1 | Interrupt acknowledge; clears the overflow flag |
| cnt_o | output | 8 | Current count |
| dir_o | output | 1 | Counting direction, 1 = down |
| top_o | output | 1 | Count equals 0xFF |
| bottom_o | output | 1 | Count equals 0x00 |
| ovf_o | output | 1 | Overflow flag |

## Verification
The following results all appear one clock edge after the cycle in which their tap pulse, bus write or clear input is held high:

- the count,
- the direction bit,
- the overflow flag.

`top_o` and `bottom_o` follow the count with no further delay. The bench changes inputs on the falling edge and holds each pulse for exactly one rising edge. It samples on the next falling edge, so every check sees the state just after the edge that consumed the stimulus. The same-cycle cases need a tick together with a write, or a set together with a clear. For these the bench drives both inputs before a single edge, then checks which of them won.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_NORM = 2'b00,
    MODE_DUAL = 2'b01,
    MODE_CTC  = 2'b10,
    MODE_FAST = 2'b11
  } wave_mode_e;

endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
  parameter int SEL_W = 3,
  parameter int TAP_N = (1 << SEL_W) - 1
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [TAP_N-1:0] taps,
  output logic             tick
);

  logic [TAP_N-1:0] hit;

  // select value g+1 picks tap g; select value 0 picks nothing
  for (genvar g = 0; g < TAP_N; g++) begin : g_tap
    assign hit[g] = taps[g] & (sel == SEL_W'(g + 1));
  end

  assign tick = |hit;

endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  wave_mode_e       mode,
  input  logic [CNT_W-1:0] cmp,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_dn,
  output logic             ovf_evt,
  output logic             at_top,
  output logic             at_bottom
);

  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  typedef struct packed {
    logic [CNT_W-1:0] nxt;
    logic             dn;
    logic             ovf;
  } step_t;

  // next count, direction and overflow request for one tick
  function automatic step_t calc_step(input logic [CNT_W-1:0] c,
                                      input wave_mode_e       m,
                                      input logic             d,
                                      input logic [CNT_W-1:0] cv);
    step_t s;
    logic  eff;
    s = '0;
    case (m)
      MODE_DUAL: begin
        eff   = (c == MAXV) ? 1'b1 : ((c == '0) ? 1'b0 : d);
        s.nxt = eff ? (c - ONE) : (c + ONE);
        s.dn  = eff;
        s.ovf = eff && (c == ONE);
      end
      MODE_CTC: begin
        s.nxt = (c == cv) ? '0 : (c + ONE);
        s.dn  = 1'b0;
        s.ovf = (c == MAXV);
      end
      default: begin
        s.nxt = c + ONE;
        s.dn  = 1'b0;
        s.ovf = (c == MAXV);
      end
    endcase
    return s;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             dir_q;
  step_t            step;

  always_comb step = calc_step(cnt_q, mode, dir_q, cmp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      if (wr_en) begin
        cnt_q <= wr_data;
      end else if (tick) begin
        cnt_q <= step.nxt;
        dir_q <= step.dn;
      end
      if (mode != MODE_DUAL) dir_q <= 1'b0;
    end
  end

  assign cnt       = cnt_q;
  assign dir_dn    = dir_q;
  assign ovf_evt   = tick & ~wr_en & step.ovf;
  assign at_top    = (cnt_q == MAXV);
  assign at_bottom = (cnt_q == '0);

endmodule

// File: rtl/tmr_ovf_flag.sv
module tmr_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr_w1c,
  input  logic ack,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (!rst_n)              flag <= 1'b0;
    else if (set)            flag <= 1'b1;
    else if (clr_w1c || ack) flag <= 1'b0;
  end

endmodule

// File: rtl/updown_tmr_core.sv
module updown_tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3,
  parameter int MODE_W = 2,
  localparam int TAP_N = (1 << SEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  clk_sel,
  input  logic [TAP_N-1:0]  tap_i,
  input  logic [MODE_W-1:0] wave_mode,
  input  logic [CNT_W-1:0]  cmp_val,
  input  logic              cpu_wr_en,
  input  logic [CNT_W-1:0]  cpu_wr_data,
  input  logic              ovf_w1c,
  input  logic              int_ack,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              dir_o,
  output logic              top_o,
  output logic              bottom_o,
  output logic              ovf_o
);

  logic       tick_w;
  logic       ovf_set_w;
  wave_mode_e mode_w;

  assign mode_w = wave_mode_e'(wave_mode);

  tmr_tick_sel #(.SEL_W(SEL_W), .TAP_N(TAP_N)) u_tick (
    .sel  (clk_sel),
    .taps (tap_i),
    .tick (tick_w)
  );

  tmr_count_unit #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_w),
    .mode      (mode_w),
    .cmp       (cmp_val),
    .wr_en     (cpu_wr_en),
    .wr_data   (cpu_wr_data),
    .cnt       (cnt_o),
    .dir_dn    (dir_o),
    .ovf_evt   (ovf_set_w),
    .at_top    (top_o),
    .at_bottom (bottom_o)
  );

  tmr_ovf_flag u_ovf (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (ovf_set_w),
    .clr_w1c (ovf_w1c),
    .ack     (int_ack),
    .flag    (ovf_o)
  );

endmodule

// File: rtl/updown_tmr_core_chk.sv
module updown_tmr_core_chk #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3,
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  clk_sel,
  input logic [MODE_W-1:0] wave_mode,
  input logic [CNT_W-1:0]  cmp_val,
  input logic              cpu_wr_en,
  input logic [CNT_W-1:0]  cpu_wr_data,
  input logic              ovf_w1c,
  input logic              int_ack,
  input logic [CNT_W-1:0]  cnt_o,
  input logic              dir_o,
  input logic              top_o,
  input logic              bottom_o,
  input logic              ovf_o,
  input logic              tick_w,
  input logic              ovf_set_w
);

  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == '0 && !cpu_wr_en) |=> $stable(cnt_o));

  // R8
  cpu_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_en |=> (cnt_o == $past(cpu_wr_data)));

  // R3
  norm_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_mode == 2'b00 && tick_w && !cpu_wr_en) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

  // R4
  dual_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_mode == 2'b01 && tick_w && !cpu_wr_en && top_o) |=> (dir_o && cnt_o == MAXV - 1'b1));

  // R5
  ctc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_mode == 2'b10 && tick_w && !cpu_wr_en && cnt_o == cmp_val) |=> bottom_o);

  // R9
  ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(tick_w && !cpu_wr_en));

  // R10
  ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_w1c || int_ack) && !ovf_set_w) |=> !ovf_o);

endmodule

bind updown_tmr_core updown_tmr_core_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W), .MODE_W(MODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clk_sel     (clk_sel),
  .wave_mode   (wave_mode),
  .cmp_val     (cmp_val),
  .cpu_wr_en   (cpu_wr_en),
  .cpu_wr_data (cpu_wr_data),
  .ovf_w1c     (ovf_w1c),
  .int_ack     (int_ack),
  .cnt_o       (cnt_o),
  .dir_o       (dir_o),
  .top_o       (top_o),
  .bottom_o    (bottom_o),
  .ovf_o       (ovf_o),
  .tick_w      (tick_w),
  .ovf_set_w   (ovf_set_w)
);

// File: tb/tb_updown_tmr_core.sv
module tb_updown_tmr_core;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] clk_sel;
  logic [6:0] tap_i;
  logic [1:0] wave_mode;
  logic [7:0] cmp_val;
  logic       cpu_wr_en;
  logic [7:0] cpu_wr_data;
  logic       ovf_w1c;
  logic       int_ack;
  logic [7:0] cnt_o;
  logic       dir_o, top_o, bottom_o, ovf_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  updown_tmr_core dut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .tap_i(tap_i),
    .wave_mode(wave_mode), .cmp_val(cmp_val), .cpu_wr_en(cpu_wr_en),
    .cpu_wr_data(cpu_wr_data), .ovf_w1c(ovf_w1c), .int_ack(int_ack),
    .cnt_o(cnt_o), .dir_o(dir_o), .top_o(top_o), .bottom_o(bottom_o),
    .ovf_o(ovf_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one tick on the tap picked by the current clk_sel
  task automatic tick1();
    tap_i = '0;
    tap_i[clk_sel - 3'd1] = 1'b1;
    @(negedge clk);
    tap_i = '0;
  endtask

  task automatic wr(input logic [7:0] d);
    cpu_wr_en = 1'b1; cpu_wr_data = d;
    @(negedge clk);
    cpu_wr_en = 1'b0;
  endtask

  task automatic clr_ovf();
    ovf_w1c = 1'b1;
    @(negedge clk);
    ovf_w1c = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 count", cnt_o, 8'h00);
    check("R1 ovf", ovf_o, 0);
    check("R1 dir", dir_o, 0);
    check("R7 bottom at 0", bottom_o, 1);
    check("R7 top at 0", top_o, 0);
  endtask

  task automatic t_stop();
    clk_sel = 3'd0; tap_i = '1;
    repeat (4) @(negedge clk);
    check("R2 stopped holds", cnt_o, 8'h00);
    wr(8'h5A);
    check("R8 write while stopped", cnt_o, 8'h5A);
    @(negedge clk);
    check("R2 stopped after write", cnt_o, 8'h5A);
    tap_i = '0;
  endtask

  task automatic t_select();
    clk_sel = 3'd3;
    tap_i = 7'b0000011;
    @(negedge clk);
    tap_i = '0;
    check("R2 unselected taps ignored", cnt_o, 8'h5A);
    tap_i = 7'b0000100;
    @(negedge clk);
    tap_i = '0;
    check("R2 selected tap advances", cnt_o, 8'h5B);
  endtask

  task automatic t_normal();
    clk_sel = 3'd1; wave_mode = 2'b00;
    wr(8'hFD);
    tick1(); check("R3 step", cnt_o, 8'hFE);
    tick1(); check("R3 to max", cnt_o, 8'hFF);
    check("R7 top at FF", top_o, 1);
    check("R9 no ovf before wrap", ovf_o, 0);
    tick1(); check("R3 wrap", cnt_o, 8'h00);
    check("R9 ovf on wrap", ovf_o, 1);
    check("R7 bottom after wrap", bottom_o, 1);
  endtask

  task automatic t_ovf_clear();
    clr_ovf();
    check("R10 w1c clears", ovf_o, 0);
    wr(8'hFF); tick1();
    check("R9 ovf again", ovf_o, 1);
    int_ack = 1'b1; @(negedge clk); int_ack = 1'b0;
    check("R10 ack clears", ovf_o, 0);
    wr(8'hFF);
    int_ack = 1'b1; tick1(); int_ack = 1'b0;
    check("R10 set wins over ack", ovf_o, 1);
    clr_ovf();
  endtask

  task automatic t_dual();
    wave_mode = 2'b01;
    wr(8'hFE);
    tick1(); check("R4 rise to FF", cnt_o, 8'hFF);
    check("R4 dir up while rising", dir_o, 0);
    tick1(); check("R4 turn at top", cnt_o, 8'hFE);
    check("R4 dir down after turn", dir_o, 1);
    check("R9 no ovf at top turn", ovf_o, 0);
    tick1(); check("R4 falling", cnt_o, 8'hFD);
    wr(8'h02);
    check("R8 write keeps dir", dir_o, 1);
    tick1(); check("R4 fall to 01", cnt_o, 8'h01);
    check("R9 no ovf at 01", ovf_o, 0);
    tick1(); check("R4 reach bottom", cnt_o, 8'h00);
    check("R9 ovf at bottom", ovf_o, 1);
    tick1(); check("R4 rise from bottom", cnt_o, 8'h01);
    check("R4 dir up at bottom", dir_o, 0);
    clr_ovf();
  endtask

  task automatic t_ctc();
    wave_mode = 2'b10; cmp_val = 8'h05;
    wr(8'h03);
    tick1(); check("R5 step", cnt_o, 8'h04);
    tick1(); check("R5 reach cmp", cnt_o, 8'h05);
    tick1(); check("R5 clear on match", cnt_o, 8'h00);
    check("R9 no ovf on match", ovf_o, 0);
    tick1(); check("R5 count after clear", cnt_o, 8'h01);
  endtask

  task automatic t_fast();
    wave_mode = 2'b11;
    wr(8'hFE);
    tick1(); check("R6 step", cnt_o, 8'hFF);
    tick1(); check("R6 wrap", cnt_o, 8'h00);
    check("R9 ovf fast", ovf_o, 1);
    clr_ovf();
  endtask

  task automatic t_prio();
    wave_mode = 2'b10; cmp_val = 8'h07;
    wr(8'h07);
    cpu_wr_en = 1'b1; cpu_wr_data = 8'h42;
    tick1(); cpu_wr_en = 1'b0;
    check("R8 write beats clear", cnt_o, 8'h42);
    wave_mode = 2'b00;
    wr(8'hFF);
    cpu_wr_en = 1'b1; cpu_wr_data = 8'h10;
    tick1(); cpu_wr_en = 1'b0;
    check("R8 write beats wrap", cnt_o, 8'h10);
    check("R8 no ovf on write", ovf_o, 0);
  endtask

  initial begin
    rst_n = 1'b0; clk_sel = '0; tap_i = '0; wave_mode = '0; cmp_val = '0;
    cpu_wr_en = 1'b0; cpu_wr_data = '0; ovf_w1c = 1'b0; int_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stop();
    t_select();
    t_normal();
    t_ovf_clear();
    t_dual();
    t_ctc();
    t_fast();
    t_prio();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule